// File: doc/BRIEF.md
# Write-Once Flash Page Buffer

This block is the staging buffer that gathers instruction words before they are programmed into one page of a flash array. Each load strobe writes a 16-bit word into the slot selected by the word-offset field of the address pointer. A per-slot valid bit makes every slot write-once: once a slot holds a word, further loads to that slot are dropped and a sticky error flag is raised until the buffer is next cleared.

The buffer clears itself in four ways: when a page write finishes, on the command that re-enables reads of the read-while-write section, when an EEPROM write happens while words are being loaded, and on reset. A cleared slot reads as all ones, which is the erased state of flash. Between the start and the end of a page write the contents are frozen and are read by the array through the read port. The flash array itself and the command decoder lie outside this block.

Top module: `flash_page_buf`

## Requirements
- R1: A load (`load_i` high at a rising clock edge, buffer not frozen, no clear request in that cycle) to an empty slot stores `load_data_i` at slot `load_off_i`. Reading that slot through `rd_off_i` returns the stored word from the edge onward.
- R2: A slot that has not been loaded since the last clear reads as 16'hFFFF.
- R3: A load to a slot that already holds a word is dropped. The slot keeps its first word, and every other slot is unchanged.
- R4: A dropped duplicate load sets `dup_err_o` at that edge. The flag then stays high until the next clear.
- R5: `wr_done_i` clears the buffer at that edge: all slots read 16'hFFFF, `dup_err_o` goes low, and the frozen state ends.
- R6: `rww_en_i` clears the buffer at that edge while loading.
- R7: `ee_write_i` clears the buffer at that edge while loading, so every loaded word is discarded.
- R8: When `rst_ni` is low, the buffer is cleared and `dup_err_o` is low.
- R9: From the edge that samples `wr_start_i` until `wr_done_i`, the buffer is frozen. Loads, `rww_en_i` and `ee_write_i` have no effect, and the contents remain readable unchanged.
- R10: A clear request in the same cycle as a load wins. The load is dropped and the slot reads 16'hFFFF.
- R11: After a clear, a slot that was loaded before can be loaded again with a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe |
| load_off_i | input | 5 | Word offset of the load (pointer low field) |
| load_data_i | input | 16 | Word to load (high:low register pair) |
| wr_start_i | input | 1 | Page write begins; freeze contents |
| wr_done_i | input | 1 | Page write complete; clear buffer |
| rww_en_i | input | 1 | Read-while-write section re-enable command; clear buffer |
| ee_write_i | input | 1 | EEPROM write event; discard loaded words |
| rd_off_i | input | 5 | Read offset for the array interface |
| rd_data_o | output | 16 | Word at `rd_off_i`, 16'hFFFF if the slot is empty |
| dup_err_o | output | 1 | Sticky duplicate-load error |

## Verification
The bench goes after second loads to a slot that is already full. A design without the write-once guard would overwrite the first word, and one that merely flagged the error would still corrupt the data. It checks that a clear request in the same cycle as a load wins, since a design with the wrong priority would leave a stray word after an erase. It tries loads, EEPROM writes and re-enable commands while a page write is in flight. A buffer that was not frozen would hand the array changed or emptied data. It also checks that the error flag survives later good loads but drops on each kind of clear, and that slots can be refilled after a clear.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic {
    PH_LOAD  = 1'b0,
    PH_WRITE = 1'b1
  } pb_phase_e;
endpackage

// File: rtl/pb_ctrl.sv
module pb_ctrl
  import pb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic wr_start_i,
  input  logic wr_done_i,
  input  logic rww_en_i,
  input  logic ee_write_i,
  output logic erase_o,
  output logic load_go_o,
  output logic busy_o
);
  pb_phase_e phase_q, phase_d;

  assign busy_o    = (phase_q == PH_WRITE);
  // clear requests other than write completion are ignored while frozen
  assign erase_o   = wr_done_i | (~busy_o & (rww_en_i | ee_write_i));
  assign load_go_o = load_i & ~busy_o & ~erase_o;

  always_comb begin
    phase_d = phase_q;
    if (wr_done_i)                 phase_d = PH_LOAD;
    else if (!busy_o && wr_start_i) phase_d = PH_WRITE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_LOAD;
    else         phase_q <= phase_d;
  end

  AST_DONE_ENDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_i |=> !busy_o) else $error("write phase survived completion"); // R5
endmodule

// File: rtl/pb_valid.sv
module pb_valid #(
  parameter int WORDS = 32,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_go_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             erase_i,
  output logic [WORDS-1:0] valid_o,
  output logic             accept_o,
  output logic             dup_err_o
);
  logic [WORDS-1:0] valid_q;
  logic             dup_err_q;
  logic             in_range;
  logic             hit;
  logic             dup;

  assign in_range  = (32'(off_i) < WORDS);
  assign hit       = in_range & valid_q[off_i];
  assign accept_o  = load_go_i & in_range & ~hit;
  assign dup       = load_go_i & hit;
  assign valid_o   = valid_q;
  assign dup_err_o = dup_err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= '0;
      dup_err_q <= 1'b0;
    end else if (erase_i) begin
      valid_q   <= '0;
      dup_err_q <= 1'b0;
    end else begin
      if (accept_o) valid_q[off_i] <= 1'b1;
      if (dup)      dup_err_q      <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_err_q && !erase_i |=> dup_err_q) else $error("error flag dropped"); // R4
  AST_ERASE_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (valid_q == '0) && !dup_err_q) else $error("erase incomplete"); // R5
  AST_DUP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_go_i && hit |=> dup_err_q) else $error("duplicate not flagged"); // R4
endmodule

// File: rtl/pb_store.sv
module pb_store #(
  parameter int WORDS  = 32,
  parameter int DATA_W = 16,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [WORDS-1:0]  valid_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[i] <= '1;
      else if (we_i && off_i == OFF_W'(i))     mem_q[i] <= data_i;
    end

    AST_LOAD_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && off_i == OFF_W'(i) |=> mem_q[i] == $past(data_i)) else $error("load lost"); // R1
    AST_OTHERS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && off_i == OFF_W'(i)) |=> $stable(mem_q[i])) else $error("slot disturbed"); // R3
  end

  // empty slots mask stored data, so a clear never has to touch the words
  always_comb begin
    rd_data_o = '1;
    if (32'(rd_off_i) < WORDS && valid_i[rd_off_i]) rd_data_o = mem_q[rd_off_i];
  end
endmodule

// File: rtl/flash_page_buf.sv
module flash_page_buf #(
  parameter int WORDS  = 32,
  parameter int DATA_W = 16,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [OFF_W-1:0]  load_off_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              wr_start_i,
  input  logic              wr_done_i,
  input  logic              rww_en_i,
  input  logic              ee_write_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              dup_err_o
);
  logic             erase;
  logic             load_go;
  logic             busy;
  logic             accept;
  logic [WORDS-1:0] valid;

  pb_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .wr_start_i (wr_start_i),
    .wr_done_i  (wr_done_i),
    .rww_en_i   (rww_en_i),
    .ee_write_i (ee_write_i),
    .erase_o    (erase),
    .load_go_o  (load_go),
    .busy_o     (busy)
  );

  pb_valid #(.WORDS(WORDS)) u_valid (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_go_i (load_go),
    .off_i     (load_off_i),
    .erase_i   (erase),
    .valid_o   (valid),
    .accept_o  (accept),
    .dup_err_o (dup_err_o)
  );

  pb_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (accept),
    .off_i     (load_off_i),
    .data_i    (load_data_i),
    .valid_i   (valid),
    .rd_off_i  (rd_off_i),
    .rd_data_o (rd_data_o)
  );

  AST_FROZEN_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !wr_done_i |=> $stable(valid)) else $error("contents moved while frozen"); // R9
  AST_CLEAR_BEATS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (wr_done_i || (!busy && (rww_en_i || ee_write_i))) |=> valid == '0)
    else $error("load survived clear"); // R10
endmodule

// File: tb/tb_flash_page_buf.sv
`timescale 1ns/1ps
module tb_flash_page_buf;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [4:0]  load_off_i = '0;
  logic [15:0] load_data_i = '0;
  logic        wr_start_i = 1'b0;
  logic        wr_done_i = 1'b0;
  logic        rww_en_i = 1'b0;
  logic        ee_write_i = 1'b0;
  logic [4:0]  rd_off_i = '0;
  logic [15:0] rd_data_o;
  logic        dup_err_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  flash_page_buf dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_off_i(load_off_i),
    .load_data_i(load_data_i), .wr_start_i(wr_start_i), .wr_done_i(wr_done_i),
    .rww_en_i(rww_en_i), .ee_write_i(ee_write_i), .rd_off_i(rd_off_i),
    .rd_data_o(rd_data_o), .dup_err_o(dup_err_o)
  );

  localparam int NV = 8;
  localparam logic [4:0]  V_OFF  [NV] = '{5'd0, 5'd31, 5'd5, 5'd0, 5'd16, 5'd31, 5'd1, 5'd5};
  localparam logic [15:0] V_DATA [NV] = '{16'h1234, 16'hABCD, 16'h0000, 16'h5555,
                                          16'hFFFF, 16'h0001, 16'h8001, 16'h7777};

  logic [15:0] model [32];
  bit          mvalid [32];
  bit          merr;

  task automatic cyc(input logic ld, input logic [4:0] off, input logic [15:0] d,
                     input logic ws, input logic wd, input logic rw, input logic ee);
    @(negedge clk_i);
    load_i = ld; load_off_i = off; load_data_i = d;
    wr_start_i = ws; wr_done_i = wd; rww_en_i = rw; ee_write_i = ee;
    @(negedge clk_i);
    load_i = 1'b0; wr_start_i = 1'b0; wr_done_i = 1'b0; rww_en_i = 1'b0; ee_write_i = 1'b0;
  endtask

  task automatic chk_rd(input logic [4:0] off, input logic [15:0] exp, input string req);
    rd_off_i = off;
    #1;
    checks++;
    if (rd_data_o !== exp) begin
      errors++;
      $display("FAIL %s rd[%0d] got %h expected %h", req, off, rd_data_o, exp);
    end
  endtask

  task automatic chk_err(input logic exp, input string req);
    #1;
    checks++;
    if (dup_err_o !== exp) begin
      errors++;
      $display("FAIL %s dup_err got %b expected %b", req, dup_err_o, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin model[i] = 16'hFFFF; mvalid[i] = 1'b0; end
    merr = 1'b0;
    #35;
    // R8: reset state
    chk_rd(5'd0, 16'hFFFF, "R8");
    chk_rd(5'd31, 16'hFFFF, "R8");
    chk_err(1'b0, "R8");
    rst_ni = 1'b1;

    // R1 R3 R4: table walk, write-once model
    for (int v = 0; v < NV; v++) begin
      cyc(1'b1, V_OFF[v], V_DATA[v], 1'b0, 1'b0, 1'b0, 1'b0);
      if (mvalid[V_OFF[v]]) merr = 1'b1;
      else begin model[V_OFF[v]] = V_DATA[v]; mvalid[V_OFF[v]] = 1'b1; end
      chk_rd(V_OFF[v], model[V_OFF[v]], "R1/R3");
      chk_err(merr, "R4");
    end
    chk_rd(5'd2, 16'hFFFF, "R2");
    chk_rd(5'd30, 16'hFFFF, "R2");
    chk_rd(5'd0, 16'h1234, "R3");

    // R9: freeze during page write
    cyc(1'b0, 5'd0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 5'd7, 16'h2222, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_rd(5'd7, 16'hFFFF, "R9");
    cyc(1'b0, 5'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk_rd(5'd0, 16'h1234, "R9");
    cyc(1'b0, 5'd0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk_rd(5'd31, 16'hABCD, "R9");
    chk_err(1'b1, "R9");

    // R5: completion clears
    cyc(1'b0, 5'd0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk_rd(5'd0, 16'hFFFF, "R5");
    chk_rd(5'd31, 16'hFFFF, "R5");
    chk_err(1'b0, "R5");

    // R11: reload after clear
    cyc(1'b1, 5'd0, 16'hC0DE, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_rd(5'd0, 16'hC0DE, "R11");
    chk_err(1'b0, "R11");

    // R6: re-enable command clears; duplicate flag cleared too
    cyc(1'b1, 5'd0, 16'h1111, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_err(1'b1, "R4");
    cyc(1'b0, 5'd0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk_rd(5'd0, 16'hFFFF, "R6");
    chk_err(1'b0, "R6");

    // R7: EEPROM write discards loads
    cyc(1'b1, 5'd9, 16'h9999, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_rd(5'd9, 16'h9999, "R1");
    cyc(1'b0, 5'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk_rd(5'd9, 16'hFFFF, "R7");

    // R10: clear beats same-cycle load
    cyc(1'b1, 5'd12, 16'h4242, 1'b0, 1'b0, 1'b1, 1'b0);
    chk_rd(5'd12, 16'hFFFF, "R10");
    cyc(1'b1, 5'd13, 16'h4343, 1'b0, 1'b0, 1'b0, 1'b1);
    chk_rd(5'd13, 16'hFFFF, "R10");
    cyc(1'b1, 5'd14, 16'h4444, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_rd(5'd14, 16'h4444, "R11");

    // R8: mid-run reset
    cyc(1'b1, 5'd14, 16'h5050, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_err(1'b1, "R4");
    #3 rst_ni = 1'b0;
    #5;
    chk_rd(5'd14, 16'hFFFF, "R8");
    chk_err(1'b0, "R8");
    rst_ni = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule